// File: doc/BRIEF.md
# Soft-Start Closed-Loop Bridge PWM Regulator

This block produces the on/off phase for an H-bridge while it runs a motor in either direction, and adjusts the duty cycle so that the averaged bridge voltage follows a digital setpoint. The averaged voltage arrives as a measurement word at four times the setpoint scale. At every regulation update the block compares the measurement, divided by four, with the setpoint. It raises the duty by one step when the measurement is low and lowers it by one step when the measurement is high. A current-limit flag that stays set long enough overrides any request to raise the duty and forces it down.

The duty is cleared whenever the bridge is idle (coasting or braking). Each entry into driving therefore ramps up from zero, and the update interval bounds the time for a full ramp. When the setpoint is out of reach of the supply, the duty saturates at full scale and the bridge is simply held on. The bridge controller downstream drives the selected diagonal during the on phase and turns on both high-side switches during the off phase, so that the winding current recirculates.

Top module: `soft_start_pwm_reg`

## Requirements
- R1: The `mode` input is encoded as 2'b00 coast, 2'b01 reverse, 2'b10 forward and 2'b11 brake. Only reverse and forward drive. In coast or brake, `duty` reads 0 and `pwm_on` reads 0 from the first clock edge taken in that mode.
- R2: On entry into a driving mode from coast or brake, the duty starts at 0. The first regulation update happens on the UPDATE_DIV-th rising edge spent in the driving mode, and each later update follows UPDATE_DIV edges after the one before.
- R3: At an update without an active limit, the duty rises by exactly 1 if floor(meas/4) < setpoint, falls by exactly 1 if floor(meas/4) > setpoint, and is unchanged if they are equal. Between updates the duty does not change.
- R4: The duty saturates at 0 and at 255 and never wraps around.
- R5: The current limit becomes active only after `ilim_over` has been high on DEGLITCH_CYC consecutive rising edges. A shorter burst changes nothing.
- R6: At an update while the limit is active, the duty falls by 1 (or stays at 0), whatever the result of the comparison.
- R7: The PWM period is PWM_PERIOD cycles. A phase counter restarts at 0 on entry into driving and runs through 0..PWM_PERIOD-1. `pwm_on` is high while count*255 < duty*PWM_PERIOD, which gives ceil(duty*PWM_PERIOD/255) on-cycles per period.
- R8: With duty 255 in a driving mode, `pwm_on` stays high for the whole period. With duty 0, it stays low.
- R9: A direct change between forward and reverse keeps the current duty and the current phase.
- R10: After a synchronous reset, `duty` is 0 and `pwm_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Decoded bridge mode (see R1) |
| setpoint | input | SET_W | Target averaged voltage, already divided by four |
| meas | input | SET_W+2 | Sampled averaged bridge voltage, full scale |
| ilim_over | input | 1 | Sense voltage above the current limit, raw |
| pwm_on | output | 1 | High in the drive phase, low in the recirculation phase |
| duty | output | DUTY_W | Present duty value |

## Verification
The assertions assume that `mode`, `meas`, `setpoint` and `ilim_over` are synchronous to `clk` and do not change near the rising edge. They also assume that reset is held low from time zero until the first edges have settled every register. The bench drives every input on the falling edge and samples outputs one nanosecond after the rising edge. It keeps `meas` within its SET_W+2 bit range, so that all three comparison outcomes, including exact equality, are reachable. The random phase changes the mode only rarely and toggles the limit flag in bursts both shorter and longer than the deglitch window, so that each assertion precondition occurs.

// File: rtl/pwm_reg_pkg.sv
`timescale 1ns/1ps
// pwm_reg_pkg
// Shared types for the soft-start bridge PWM regulator.
// Assumes the mode word is already decoded from the host control pins.
package pwm_reg_pkg;

    typedef enum logic [1:0] {
        MODE_COAST = 2'b00,
        MODE_REV   = 2'b01,
        MODE_FWD   = 2'b10,
        MODE_BRAKE = 2'b11
    } bridge_mode_e;

    // True for the two modes in which the bridge is driven.
    function automatic logic mode_drives(input bridge_mode_e m);
        return (m == MODE_FWD) || (m == MODE_REV);
    endfunction

endpackage

// File: rtl/update_pacer.sv
`timescale 1ns/1ps
// update_pacer
// Emits a one-cycle regulation tick every DIV cycles while the bridge drives.
// The count restarts whenever driving stops, so the first tick after an
// entry lands on the DIV-th edge spent driving.
// Assumes DIV >= 2.
module update_pacer #(
    parameter int DIV = 9411
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Interval counter: cleared when idle, wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/limit_filter.sv
`timescale 1ns/1ps
// limit_filter
// Deglitches the raw current-limit comparator flag. The limit counts as
// active only once the flag has been seen high on HOLD_CYC consecutive
// edges. Any low sample restarts the count.
// Assumes over_raw is synchronous to clk.
module limit_filter #(
    parameter int HOLD_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic over_raw,
    output logic limit_act
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

    logic [CW-1:0] run_len;

    // Saturating run-length counter of consecutive high samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !over_raw) begin
            run_len <= '0;
        end else if (run_len != FULL) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign limit_act = (run_len == FULL);

    // R5: the limit can only turn on right after the raw flag was high.
    a_r5_rise_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(limit_act) |-> $past(over_raw));

    // R5: a low raw sample always removes an active limit on the next edge.
    a_r5_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!over_raw) |=> !limit_act);

endmodule

// File: rtl/duty_ramp.sv
`timescale 1ns/1ps
// duty_ramp
// Holds the duty register and moves it by one LSB per regulation tick.
// Priority at a tick: active current limit (down) first, then a measurement
// below the setpoint (up), then one above it (down). The register saturates
// at both ends and is cleared whenever the bridge is not driving.
// Assumes meas is the averaged output at four times the setpoint scale.
module duty_ramp #(
    parameter int DUTY_W = 8,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              limit_act,
    input  logic [SET_W+1:0]  meas,
    input  logic [SET_W-1:0]  setpt,
    output logic [DUTY_W-1:0] duty
);
    localparam logic [DUTY_W-1:0] DMAX = {DUTY_W{1'b1}};

    logic meas_low;
    logic meas_high;

    // Compare floor(meas/4) with the setpoint without losing the low bits.
    always_comb begin
        meas_low  = meas < {setpt, 2'b00};
        meas_high = meas[SET_W+1:2] > setpt;
    end

    // Duty register: cleared when idle, stepped on ticks, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            duty <= '0;
        end else if (tick) begin
            if (limit_act) begin
                if (duty != '0) duty <= duty - 1'b1;
            end else if (meas_low) begin
                if (duty != DMAX) duty <= duty + 1'b1;
            end else if (meas_high) begin
                if (duty != '0) duty <= duty - 1'b1;
            end
        end
    end

    // R1: an idle mode leaves the duty at zero after the edge.
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (duty == '0));

    // R3: without a tick the duty holds.
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(duty));

    // R4: no wrap from full scale to zero.
    a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == DMAX) |=> (duty != '0));

    // R4: no wrap from zero to full scale.
    a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == '0) |=> (duty != DMAX));

    // R6: an active limit never lets a tick raise the duty.
    a_r6_limit_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && limit_act) |=> (duty <= $past(duty)));

endmodule

// File: rtl/pwm_slicer.sv
`timescale 1ns/1ps
// pwm_slicer
// Free-running period counter compared against the scaled duty. The on
// phase lasts while count*DMAX < duty*PERIOD, so duty 0 never turns on and
// full-scale duty stays on for the whole period.
// Assumes PERIOD >= 2. The counter restarts at zero on entry into driving.
module pwm_slicer #(
    parameter int PERIOD = 4494,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_on
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int PW    = CNT_W + DUTY_W + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
    localparam logic [PW-1:0] DMAX_W = PW'((1 << DUTY_W) - 1);
    localparam logic [PW-1:0] PER_W  = PW'(PERIOD);

    logic [CNT_W-1:0] phase;
    logic [PW-1:0]    lhs;
    logic [PW-1:0]    rhs;

    // Period counter: held at zero when idle, wraps at PERIOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Scale both sides to a common base and decide the phase.
    always_comb begin
        lhs    = PW'(phase) * DMAX_W;
        rhs    = PW'(duty) * PER_W;
        pwm_on = run && (lhs < rhs);
    end

    // R8: full-scale duty while driving means continuously on.
    a_r8_full_on: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == {DUTY_W{1'b1}}) |-> pwm_on);

    // R8: zero duty means continuously off.
    a_r8_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !pwm_on);

endmodule

// File: rtl/soft_start_pwm_reg.sv
`timescale 1ns/1ps
// soft_start_pwm_reg
// Top of the closed-loop bridge PWM regulator: pacing, limit deglitch, duty
// stepping and PWM generation. Outputs go to the bridge controller, which
// drives the selected diagonal while pwm_on is high and recirculates through
// both high-side switches while it is low.
// Assumes all inputs are synchronous to clk and meas is already sampled.
module soft_start_pwm_reg
    import pwm_reg_pkg::*;
#(
    parameter int DUTY_W       = 8,
    parameter int SET_W        = 8,
    parameter int PWM_PERIOD   = 4494,
    parameter int UPDATE_DIV   = 9411,
    parameter int DEGLITCH_CYC = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [SET_W-1:0]  setpoint,
    input  logic [SET_W+1:0]  meas,
    input  logic              ilim_over,
    output logic              pwm_on,
    output logic [DUTY_W-1:0] duty
);
    logic run;
    logic tick;
    logic limit_act;

    // Decode whether the present mode drives the bridge.
    always_comb begin
        run = mode_drives(bridge_mode_e'(mode));
    end

    update_pacer #(.DIV(UPDATE_DIV)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    limit_filter #(.HOLD_CYC(DEGLITCH_CYC)) u_limit (
        .clk       (clk),
        .rst_n     (rst_n),
        .over_raw  (ilim_over),
        .limit_act (limit_act)
    );

    duty_ramp #(.DUTY_W(DUTY_W), .SET_W(SET_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .limit_act (limit_act),
        .meas      (meas),
        .setpt     (setpoint),
        .duty      (duty)
    );

    pwm_slicer #(.PERIOD(PWM_PERIOD), .DUTY_W(DUTY_W)) u_slicer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .duty   (duty),
        .pwm_on (pwm_on)
    );

    // R1: an idle mode never shows the on phase.
    a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> !pwm_on);

endmodule

// File: tb/sim_soft_start_pwm_reg.sv
`timescale 1ns/1ps
module sim_soft_start_pwm_reg;
    localparam int P    = 20;
    localparam int UPD  = 8;
    localparam int DEGL = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] setpoint = 8'd0;
    logic [9:0] meas = 10'd0;
    logic       ilim = 1'b0;
    logic       pwm_on;
    logic [7:0] duty;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    soft_start_pwm_reg #(
        .DUTY_W(8), .SET_W(8), .PWM_PERIOD(P),
        .UPDATE_DIV(UPD), .DEGLITCH_CYC(DEGL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .setpoint(setpoint),
        .meas(meas), .ilim_over(ilim), .pwm_on(pwm_on), .duty(duty)
    );

    always #2.5 clk = ~clk;

    function automatic bit drives(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    // Expected on-cycles per period (R7).
    function automatic int on_cycles(input int d);
        return (d * P + 254) / 255;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model from the requirements, one step per rising edge.
    int m_tc = 0, m_dc = 0, m_duty = 0, m_pc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tc <= 0; m_dc <= 0; m_duty <= 0; m_pc <= 0;
        end else begin
            m_tc <= (!drives(mode) || m_tc == UPD - 1) ? 0 : m_tc + 1;
            m_pc <= (!drives(mode) || m_pc == P - 1) ? 0 : m_pc + 1;
            m_dc <= !ilim ? 0 : ((m_dc == DEGL) ? DEGL : m_dc + 1);
            if (!drives(mode)) m_duty <= 0;
            else if (m_tc == UPD - 1) begin
                if (m_dc == DEGL) m_duty <= (m_duty > 0) ? m_duty - 1 : 0;
                else if (int'(meas) / 4 < int'(setpoint)) m_duty <= (m_duty < 255) ? m_duty + 1 : 255;
                else if (int'(meas) / 4 > int'(setpoint)) m_duty <= (m_duty > 0) ? m_duty - 1 : 0;
            end
        end
    end

    // Cycle-by-cycle comparison against the model (R3, R7).
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(int'(duty) == m_duty, "R3 duty", int'(duty), m_duty);
            chk(pwm_on == (drives(mode) && (m_pc * 255 < m_duty * P)), "R7 pwm_on",
                int'(pwm_on), int'(drives(mode) && (m_pc * 255 < m_duty * P)));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic count_on(output int n);
        n = 0;
        for (int i = 0; i < P; i++) begin
            @(posedge clk); #1;
            if (pwm_on) n++;
        end
    endtask

    initial begin
        int n;
        int d;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(duty == 8'd0, "R10 reset duty", int'(duty), 0);
        chk(pwm_on == 1'b0, "R10 reset pwm", int'(pwm_on), 0);

        // R2: soft start from coast.
        @(negedge clk); mode = 2'b10; setpoint = 8'd200; meas = 10'd0;
        repeat (UPD - 1) @(posedge clk); #1;
        chk(duty == 8'd0, "R2 before first update", int'(duty), 0);
        @(posedge clk); #1;
        chk(duty == 8'd1, "R2 first update", int'(duty), 1);

        // R4 / R8: ramp saturates at full scale, output stays on.
        repeat (256 * UPD) @(posedge clk); #1;
        chk(duty == 8'd255, "R4 top clamp", int'(duty), 255);
        count_on(n);
        chk(n == P, "R8 full on", n, P);

        // R9: direct direction change keeps the duty.
        @(negedge clk); mode = 2'b01;
        @(posedge clk); #1;
        chk(duty == 8'd255, "R9 reverse keeps duty", int'(duty), 255);

        // R5: a burst one edge short of the window has no effect.
        @(negedge clk); ilim = 1'b1;
        repeat (DEGL - 1) @(negedge clk);
        ilim = 1'b0;
        repeat (3 * UPD) @(posedge clk); #1;
        chk(duty == 8'd255, "R5 short burst ignored", int'(duty), 255);

        // R6: sustained limit overrides the increase request.
        @(negedge clk); ilim = 1'b1;
        repeat (DEGL + 10 * UPD) @(posedge clk); #1;
        chk(duty <= 8'd246 && duty >= 8'd244, "R6 limit reduces", int'(duty), 245);
        @(negedge clk); ilim = 1'b0;

        // R3 / R7: equality holds the duty; on-count matches it.
        setpoint = 8'd100; meas = 10'd403;
        @(posedge clk); #1;
        d = int'(duty);
        repeat (3 * UPD) @(posedge clk); #1;
        chk(int'(duty) == d, "R3 equal holds", int'(duty), d);
        count_on(n);
        chk(n == on_cycles(d), "R7 on count high duty", n, on_cycles(d));

        // R3 / R4: measurement above setpoint walks down to a zero clamp.
        @(negedge clk); meas = 10'd404;
        repeat (256 * UPD) @(posedge clk); #1;
        chk(duty == 8'd0, "R4 bottom clamp", int'(duty), 0);
        count_on(n);
        chk(n == 0, "R8 zero off", n, 0);

        // R7: mid duty on-count.
        @(negedge clk); setpoint = 8'd255; meas = 10'd0;
        do begin @(posedge clk); #1; end while (duty != 8'd128);
        @(negedge clk); meas = 10'd1020;
        @(posedge clk); #1;
        d = int'(duty);
        count_on(n);
        chk(n == on_cycles(d), "R7 on count mid duty", n, on_cycles(d));

        // R1: brake clears duty and output.
        @(negedge clk); mode = 2'b11;
        @(posedge clk); #1;
        chk(duty == 8'd0, "R1 brake duty", int'(duty), 0);
        chk(pwm_on == 1'b0, "R1 brake pwm", int'(pwm_on), 0);

        // R2: re-entry from brake restarts at zero.
        @(negedge clk); mode = 2'b10; meas = 10'd0;
        repeat (UPD - 1) @(posedge clk); #1;
        chk(duty == 8'd0, "R2 re-entry start", int'(duty), 0);
        @(posedge clk); #1;
        chk(duty == 8'd1, "R2 re-entry first step", int'(duty), 1);
        repeat (5 * UPD) @(posedge clk);
        @(negedge clk); mode = 2'b00;
        @(posedge clk); #1;
        chk(duty == 8'd0, "R1 coast duty", int'(duty), 0);
        chk(pwm_on == 1'b0, "R1 coast pwm", int'(pwm_on), 0);

        // Random phase: model comparison runs every cycle.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 199) == 0) mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) mode = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01;
            if ($urandom_range(0, 49) == 0) begin
                setpoint = 8'($urandom_range(0, 255));
                meas = 10'($urandom_range(0, 1023));
            end
            if ($urandom_range(0, 15) == 0) ilim = ~ilim;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule